// File: doc/BRIEF.md
# Framebuffer Pattern Fill Engine

The fill engine is a small hardware sequencer that owns the write port of a 4096-word, 16-bit display memory. The memory holds a 64-column by 48-row picture. A processor, or any controller, issues a single start pulse instead of writing 3072 words one at a time. The engine then walks every visible pixel and either blanks the picture or paints a sparse grid of dots.

In clear mode every visible pixel is written with zero. In pattern mode a pixel takes the current colour only when its row and its column are both odd. All other pixels are written with zero. A pattern run can repeat for several passes. After each complete pass the colour moves on by a programmable step, which gives a simple shimmer effect. Typical software settings are a start colour of 0x238F, a step of 0x10 and 100 passes.

Each pixel takes two clocks. In the first clock the address and data are set up. In the second clock the write strobe is high. When the final write is over, a one-cycle done pulse is raised.

Top module: `fill_engine`

## Requirements
- R1: After reset, and for as long as no start pulse arrives, the strobe and done are low and the address and data outputs are zero.
- R2: Each pass writes exactly 3072 pixels in row-major order: rows 0..47 outer, columns 0..63 inner. The address of row r, column c is r*64+c. No address from 3072 to 4095 is ever written.
- R3: With mode_i=1 (pattern), a pixel whose row and column are both odd is written with the pass colour. Every other pixel is written with 0x0000.
- R4: With mode_i=0 (clear), all 3072 pixels are written with 0x0000 in a single pass. The colour, step and pass count are ignored.
- R5: In pattern mode the colour of pass p (counting from 0) is start + p*step, taken modulo 2^16.
- R6: The strobe is high for exactly one clock per pixel and is low between pixels. In the clock before the strobe and in the strobe clock, the address and data already carry that pixel's values.
- R7: done is high for exactly one clock, in the clock right after the last strobe of the last pass. No strobe follows it.
- R8: A start pulse that arrives while a run is in progress has no effect on the write sequence or on done.
- R9: Mode, colour, step and pass count are captured on the start pulse. Changes to them during a run do not affect that run.
- R10: In pattern mode a pass count of 0 runs one pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; only acted on while idle |
| mode_i | input | 1 | 0 = clear, 1 = pattern |
| colour_i | input | DATA_W | Colour for the first pattern pass |
| step_i | input | DATA_W | Colour increment applied after each pass |
| passes_i | input | PASS_W | Number of pattern passes (0 is treated as 1) |
| wr_addr_o | output | ADDR_W | Memory write address |
| wr_data_o | output | DATA_W | Memory write data |
| wr_en_o | output | 1 | Memory write strobe, one clock per pixel |
| done_o | output | 1 | One-cycle pulse when the run is finished |

## Verification
The assertions assume that rst is held for at least one clock before any start pulse, so that the setup/strobe alternation begins from a known idle state. They also assume that start_i is a clean synchronous level, sampled only at the rising edge. The stimulus changes every input just after the falling edge and keeps start high for one clock. The only exceptions are the deliberate disturbances, and these happen well inside a run, so the properties about setup stability and the single done pulse are never tested against a half-cycle input change.

// File: rtl/fill_pkg.sv
package fill_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2
  } fill_state_e;

  localparam logic MODE_CLEAR   = 1'b0;
  localparam logic MODE_PATTERN = 1'b1;
endpackage

// File: rtl/fill_scan.sv
module fill_scan #(
  parameter int COLS = 64,
  parameter int ROWS = 48,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  output logic [RW-1:0] nxt_row,
  output logic [CW-1:0] nxt_col,
  output logic          last
);
  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;
  logic          col_end;
  logic          row_end;

  always_comb begin
    col_end = (col_q == CW'(COLS - 1));
    row_end = (row_q == RW'(ROWS - 1));
    last    = col_end && row_end;
    if (!col_end) begin
      nxt_col = col_q + CW'(1);
      nxt_row = row_q;
    end else begin
      nxt_col = '0;
      nxt_row = row_end ? '0 : row_q + RW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      row_q <= '0;
      col_q <= '0;
    end else if (adv) begin
      row_q <= nxt_row;
      col_q <= nxt_col;
    end
  end
endmodule

// File: rtl/fill_colour.sv
module fill_colour #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_colour,
  input  logic [DATA_W-1:0] load_step,
  input  logic              advance,
  output logic [DATA_W-1:0] colour
);
  logic [DATA_W-1:0] step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      colour <= '0;
      step_q <= '0;
    end else if (load) begin
      colour <= load_colour;
      step_q <= load_step;
    end else if (advance) begin
      colour <= colour + step_q;
    end
  end
endmodule

// File: rtl/fill_engine.sv
module fill_engine #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int PASS_W = 8,
  parameter int COLS   = 64,
  parameter int ROWS   = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic [DATA_W-1:0] colour_i,
  input  logic [DATA_W-1:0] step_i,
  input  logic [PASS_W-1:0] passes_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wr_en_o,
  output logic              done_o
);
  import fill_pkg::*;

  localparam int CW = $clog2(COLS);
  localparam int RW = $clog2(ROWS);
  localparam bit COLS_POW2 = ((COLS & (COLS - 1)) == 0);

  fill_state_e       state_q;
  logic              mode_q;
  logic [PASS_W-1:0] pass_left_q;
  logic [RW-1:0]     nxt_row;
  logic [CW-1:0]     nxt_col;
  logic              last;
  logic [ADDR_W-1:0] nxt_addr;
  logic [DATA_W-1:0] nxt_data;
  logic [DATA_W-1:0] colour;
  logic              accept;
  logic              strobe_st;
  logic              final_pass;
  logic              finish;

  always_comb begin
    accept     = (state_q == ST_IDLE) && start_i;
    strobe_st  = (state_q == ST_STROBE);
    final_pass = (mode_q == MODE_CLEAR) || (pass_left_q == PASS_W'(1));
    finish     = strobe_st && last && final_pass;
  end

  fill_scan #(.COLS(COLS), .ROWS(ROWS)) u_scan (
    .clk     (clk),
    .rst     (rst),
    .clr     (accept),
    .adv     (strobe_st),
    .nxt_row (nxt_row),
    .nxt_col (nxt_col),
    .last    (last)
  );

  fill_colour #(.DATA_W(DATA_W)) u_colour (
    .clk         (clk),
    .rst         (rst),
    .load        (accept),
    .load_colour (colour_i),
    .load_step   (step_i),
    .advance     (strobe_st && last && !final_pass),
    .colour      (colour)
  );

  generate
    if (COLS_POW2) begin : g_addr_cat
      assign nxt_addr = ADDR_W'({nxt_row, nxt_col});
    end else begin : g_addr_mul
      assign nxt_addr = ADDR_W'(nxt_row) * ADDR_W'(COLS) + ADDR_W'(nxt_col);
    end
  endgenerate

  always_comb begin
    if ((mode_q == MODE_PATTERN) && nxt_row[0] && nxt_col[0])
      nxt_data = colour;
    else
      nxt_data = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      mode_q      <= MODE_CLEAR;
      pass_left_q <= '0;
      wr_addr_o   <= '0;
      wr_data_o   <= '0;
      wr_en_o     <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            mode_q      <= mode_i;
            pass_left_q <= (mode_i == MODE_CLEAR || passes_i == '0)
                           ? PASS_W'(1) : passes_i;
            wr_addr_o   <= '0;
            wr_data_o   <= '0;
            state_q     <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          wr_en_o <= 1'b1;
          state_q <= ST_STROBE;
        end
        ST_STROBE: begin
          wr_en_o <= 1'b0;
          if (finish) begin
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            if (last) pass_left_q <= pass_left_q - PASS_W'(1);
            wr_addr_o <= nxt_addr;
            wr_data_o <= nxt_data;
            state_q   <= ST_SETUP;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fill_engine_chk.sv
module fill_engine_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int COLS   = 64,
  parameter int ROWS   = 48
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              done
);
  localparam int NPIX = COLS * ROWS;

  logic dark_pixel;
  always_comb begin
    dark_pixel = ((int'(wr_addr) % COLS) % 2 == 0) ||
                 ((int'(wr_addr) / COLS) % 2 == 0);
  end

  AST_ADDR_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> int'(wr_addr) < NPIX); // R2
  AST_DARK_PIXEL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (wr_en && dark_pixel) |-> wr_data == '0); // R3
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en); // R6
  AST_SETUP_STABLE: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_en) |-> ($stable(wr_addr) && $stable(wr_data))); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(wr_en) && !wr_en)); // R7
endmodule

bind fill_engine fill_engine_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .COLS   (COLS),
  .ROWS   (ROWS)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en_o),
  .wr_addr (wr_addr_o),
  .wr_data (wr_data_o),
  .done    (done_o)
);

// File: tb/fill_engine_tb.sv
module fill_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NPIX       = 3072;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [15:0] colour_i = '0;
  logic [15:0] step_i = '0;
  logic [7:0]  passes_i = '0;
  logic [11:0] wr_addr_o;
  logic [15:0] wr_data_o;
  logic        wr_en_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fill_engine u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
    .colour_i(colour_i), .step_i(step_i), .passes_i(passes_i),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .wr_en_o(wr_en_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  function automatic logic [15:0] exp_data(bit pat, logic [15:0] c0,
                                           logic [15:0] st, int k);
    int p   = k / NPIX;
    int pix = k % NPIX;
    int r   = pix / 64;
    int c   = pix % 64;
    logic [15:0] pc = c0 + 16'(p) * st;
    if (pat && (r % 2 == 1) && (c % 2 == 1)) return pc;
    return 16'h0000;
  endfunction

  // disturb: 0 none, 1 start again while busy (R8), 2 change inputs mid-run (R9)
  task automatic run_fill(input string tag, input bit pat, input logic [15:0] c0,
                          input logic [15:0] st, input logic [7:0] np,
                          input int disturb);
    int eff   = pat ? ((np == 0) ? 1 : int'(np)) : 1;
    int total = eff * NPIX;
    int nwr = 0, addr_err = 0, data_err = 0, stab_err = 0;
    int ndone = 0, done_late = 0, post_wr = 0, max_addr = 0;
    int last_wr_cyc = -10, done_cyc = -1;
    logic [11:0] pa = '0;
    logic [15:0] pd = '0;
    logic        pw = 1'b0;
    int limit = total * 2 + 40;
    string dreq = pat ? "R3/R5" : "R4";
    @(negedge clk);
    mode_i = pat; colour_i = c0; step_i = st; passes_i = np; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int cyc = 0; cyc < limit; cyc++) begin
      if (wr_en_o) begin
        if (done_cyc >= 0) post_wr++;
        if (pw || wr_addr_o != pa || wr_data_o != pd) stab_err++;
        if (nwr < total) begin
          if (int'(wr_addr_o) != (nwr % NPIX)) addr_err++;
          if (wr_data_o != exp_data(pat, c0, st, nwr)) data_err++;
        end
        if (int'(wr_addr_o) > max_addr) max_addr = int'(wr_addr_o);
        nwr++;
        last_wr_cyc = cyc;
      end
      if (done_o) begin
        ndone++;
        if (done_cyc < 0) begin
          done_cyc = cyc;
          if (cyc != last_wr_cyc + 1) done_late++;
        end
      end
      if (done_cyc >= 0 && cyc > done_cyc + 6) break;
      pa = wr_addr_o; pd = wr_data_o; pw = wr_en_o;
      if (disturb == 1 && cyc == 300) begin
        start_i = 1'b1; mode_i = ~pat; colour_i = 16'hFFFF; passes_i = 8'd5;
      end
      if (disturb == 1 && cyc == 301) start_i = 1'b0;
      if (disturb == 2 && cyc == 300) begin
        mode_i = ~pat; colour_i = ~c0; step_i = 16'h1234; passes_i = np + 8'd3;
      end
      @(negedge clk);
    end
    check(nwr == total, "R2", {tag, " write count"}, nwr, total);
    check(addr_err == 0, "R2", {tag, " row-major address errors"}, addr_err, 0);
    check(max_addr < NPIX, "R2", {tag, " highest address"}, max_addr, NPIX - 1);
    check(data_err == 0, dreq, {tag, " pixel data errors"}, data_err, 0);
    check(stab_err == 0, "R6", {tag, " setup/strobe errors"}, stab_err, 0);
    check(ndone == 1, "R7", {tag, " done pulse count"}, ndone, 1);
    check(done_late == 0 && post_wr == 0, "R7", {tag, " done timing"},
          done_late + post_wr, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!wr_en_o && !done_o, "R1", "strobe/done after reset",
          {wr_en_o, done_o}, 0);
    check(wr_addr_o == 0 && wr_data_o == 0, "R1", "addr/data after reset",
          {wr_addr_o, wr_data_o}, 0);
    begin
      int seen = 0;
      for (int i = 0; i < 20; i++) begin
        if (wr_en_o || done_o) seen++;
        @(negedge clk);
      end
      check(seen == 0, "R1", "idle activity without start", seen, 0);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    check(1'b0, "ALL", "watchdog expired", WATCHDOG, 0);
    summary();
  end

  initial begin
    t_reset();
    // R4: clear ignores colour, step and passes
    run_fill("clear", 1'b0, 16'hBEEF, 16'h0010, 8'd7, 0);
    // R3, R5: single pass with the default colour
    run_fill("pattern1", 1'b1, 16'h238F, 16'h0010, 8'd1, 0);
    // R5: colour wraps modulo 2^16 across passes
    run_fill("pattern_wrap", 1'b1, 16'hFFF0, 16'h0010, 8'd3, 0);
    // R10: zero passes means one pass
    run_fill("pattern_zero", 1'b1, 16'h0F0F, 16'h0101, 8'd0, 0);
    // R8: start while busy is ignored
    run_fill("busy_start R8", 1'b1, 16'h1111, 16'h0200, 8'd2, 1);
    // R9: inputs changed mid-run are ignored
    run_fill("resample R9", 1'b1, 16'h4321, 16'h0008, 8'd1, 2);
    summary();
  end
endmodule